// File: doc/BRIEF.md
# Keyed Watchdog Timer with Early Warning

This block is a down-counting watchdog for a chip's control domain. A free-running prescaler divides the system clock by a power of two and gives one tick per period. While the watchdog runs, each tick decrements a 12-bit counter. When a tick arrives and the counter already reads zero, the block asserts its reset output, and that output holds until the block itself is reset. Software keeps the system alive by writing a reload key often enough. Each reload key copies the committed reload value into the counter.

Writes to the configuration registers are protected by a key. One key code opens the protected registers. Any other key code closes them again. A separate key code starts the watchdog, and after that only a reset can stop it. A compare register can raise an early warning interrupt a set number of ticks before the reset fires. That interrupt stays high until software acknowledges it. Prescaler and reload changes do not take effect at once. Each is committed a fixed number of ticks after the write, and a status bit shows the change as busy until then.

The control logic is a three-state machine. `GT_IDLE` is the state after reset: the counter is stopped. The start key moves it to `GT_RUN`. In `GT_RUN` a tick at a zero count moves it to `GT_FIRED`, which is terminal and drives the reset output. A reload key arriving in the same cycle as that tick wins, and the machine stays in `GT_RUN`. No transition leaves `GT_FIRED` except the block's reset.

Top module: `guard_timer`

## Requirements
- R1: After reset the block is in `GT_IDLE` with both outputs low. Register reads return: prescaler code 0, reload 0xFFF, window 0xFFF, early control 0 and status 0.
- R2: Writing 0x5555 to offset 0x00 opens writes to offsets 0x04 (prescaler code), 0x08 (reload, bits 11:0), 0x10 (window, bits 11:0) and 0x14 (early control). Writing any other value to offset 0x00 closes them. Writes to those offsets while closed change nothing.
- R3: Writing 0xCCCC to offset 0x00 in `GT_IDLE` loads the counter from the committed reload value and enters `GT_RUN`. No key value returns the block to `GT_IDLE`.
- R4: Writing 0xAAAA to offset 0x00 loads the counter from the committed reload value. A reload in the same cycle as a tick takes precedence over the decrement or the firing.
- R5: The prescaler gives one tick every 2^(code+2) clock cycles for codes 0 to 8. Codes above 8 behave as code 8, which is a division by 1024.
- R6: In `GT_RUN`, a tick at count zero enters `GT_FIRED`, and `wdg_rst` is high from the next cycle until reset. A tick at any other count decrements the counter, so a reload value N fires on the (N+1)-th tick.
- R7: Offset 0x14 holds a compare value in bits 11:0 and an enable in bit 15. When a tick in `GT_RUN` decrements the counter to the compare value while the enable is set, `early_irq` rises in the next cycle. It stays high until acknowledged, even after the counter moves on.
- R8: A write to offset 0x14 with bit 14 set clears `early_irq`, whether the registers are open or closed. If the registers are closed, the compare and enable fields stay unchanged. A new match in the same cycle wins over the acknowledge.
- R9: An accepted write to the prescaler sets status bit 0, and an accepted write to the reload sets status bit 1. Each bit clears after 2 further ticks, and only then does the new value take effect. Reads return the programmed value at once.
- R10: Status is read at offset 0x0C. Reads of offset 0x00 and of unmapped offsets return 0. Early control reads back with bit 14 as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 5 | Byte offset for read and write |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| wdg_rst | output | 1 | Watchdog reset request, held until reset |
| early_irq | output | 1 | Early warning interrupt, held until acknowledged |

## Verification
A write takes effect at the clock edge that samples it. Register contents and status are visible on `bus_rdata` in the following cycle. `early_irq` and `wdg_rst` come from registers, so each one changes one cycle after the tick edge that causes it. A committed prescaler or reload value first acts on the tick after the second tick following the write. A behavioural model in the bench updates at the same edge as the design and is compared at every falling edge. Directed checks are placed with margins of a whole tick period, because the prescaler phase at start is not aligned to the writes.

// File: rtl/gt_pkg.sv
package gt_pkg;
    typedef enum logic [1:0] {
        GT_IDLE  = 2'd0,
        GT_RUN   = 2'd1,
        GT_FIRED = 2'd2
    } gt_state_e;

    localparam int OFF_KEY = 'h00;
    localparam int OFF_PSC = 'h04;
    localparam int OFF_RLD = 'h08;
    localparam int OFF_STS = 'h0C;
    localparam int OFF_WIN = 'h10;
    localparam int OFF_EWC = 'h14;

    localparam logic [15:0] KEY_OPEN   = 16'h5555;
    localparam logic [15:0] KEY_FEED   = 16'hAAAA;
    localparam logic [15:0] KEY_LAUNCH = 16'hCCCC;

    localparam int EWC_ACK_BIT = 14;
    localparam int EWC_EN_BIT  = 15;
endpackage

// File: rtl/gt_prescaler.sv
module gt_prescaler #(
    parameter int CODE_W  = 4,
    parameter int MIN_LOG = 2,
    parameter int MAX_LOG = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] code,
    output logic              tick
);
    localparam int PW       = MAX_LOG;
    localparam int MAX_CODE = MAX_LOG - MIN_LOG;

    logic [PW-1:0]     pcnt;
    logic [PW-1:0]     limit;
    logic [CODE_W-1:0] eff;

    always_comb begin
        eff   = (code > CODE_W'(MAX_CODE)) ? CODE_W'(MAX_CODE) : code;
        limit = PW'((32'd1 << (32'(eff) + MIN_LOG)) - 32'd1);
        tick  = (pcnt >= limit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    pcnt <= '0;
        else if (tick) pcnt <= '0;
        else           pcnt <= pcnt + 1'b1;
    end

    // R5: the smallest division is 4, so ticks never come back to back
    p_tick_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/gt_shadow.sv
module gt_shadow #(
    parameter int             W         = 12,
    parameter int             UPD_TICKS = 2,
    parameter logic [W-1:0]   RST_VAL   = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] wval,
    input  logic         tick,
    output logic [W-1:0] prog,
    output logic [W-1:0] act,
    output logic         busy
);
    localparam int UW = (UPD_TICKS < 2) ? 1 : $clog2(UPD_TICKS);

    logic [UW-1:0] n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prog <= RST_VAL;
            act  <= RST_VAL;
            busy <= 1'b0;
            n    <= '0;
        end else if (wr) begin
            prog <= wval;
            busy <= 1'b1;
            n    <= '0;
        end else if (busy && tick) begin
            if (n == UW'(UPD_TICKS - 1)) begin
                busy <= 1'b0;
                act  <= prog;
            end else begin
                n <= n + 1'b1;
            end
        end
    end

    // R9: when the busy flag drops, the committed value equals the programmed one
    p_commit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (act == prog));
endmodule

// File: rtl/gt_regs.sv
module gt_regs
    import gt_pkg::*;
#(
    parameter int CNT_W     = 12,
    parameter int CODE_W    = 4,
    parameter int UPD_TICKS = 2,
    parameter int AW        = 5,
    parameter int DW        = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     addr,
    input  logic [DW-1:0]     wdata,
    input  logic              tick,
    output logic [DW-1:0]     rdata,
    output logic [CODE_W-1:0] psc_act,
    output logic [CNT_W-1:0]  rld_act,
    output logic [CNT_W-1:0]  cmp_val,
    output logic              irq_en,
    output logic              key_feed,
    output logic              key_launch,
    output logic              irq_ack
);
    logic              open_q;
    logic              prot_wr;
    logic [CNT_W-1:0]  win_q;
    logic [CODE_W-1:0] psc_prog;
    logic [CNT_W-1:0]  rld_prog;
    logic              psc_busy;
    logic              rld_busy;
    logic              key_wr;

    assign key_wr     = wr_en && (addr == AW'(OFF_KEY));
    assign prot_wr    = wr_en && open_q;
    assign key_feed   = key_wr && (wdata == KEY_FEED);
    assign key_launch = key_wr && (wdata == KEY_LAUNCH);
    assign irq_ack    = wr_en && (addr == AW'(OFF_EWC)) && wdata[EWC_ACK_BIT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      open_q <= 1'b0;
        else if (key_wr) open_q <= (wdata == KEY_OPEN);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_q   <= '1;
            cmp_val <= '0;
            irq_en  <= 1'b0;
        end else if (prot_wr) begin
            if (addr == AW'(OFF_WIN)) win_q <= wdata[CNT_W-1:0];
            if (addr == AW'(OFF_EWC)) begin
                cmp_val <= wdata[CNT_W-1:0];
                irq_en  <= wdata[EWC_EN_BIT];
            end
        end
    end

    gt_shadow #(.W(CODE_W), .UPD_TICKS(UPD_TICKS), .RST_VAL('0)) u_psc_shadow (
        .clk  (clk),
        .rst_n(rst_n),
        .wr   (prot_wr && (addr == AW'(OFF_PSC))),
        .wval (wdata[CODE_W-1:0]),
        .tick (tick),
        .prog (psc_prog),
        .act  (psc_act),
        .busy (psc_busy)
    );

    gt_shadow #(.W(CNT_W), .UPD_TICKS(UPD_TICKS), .RST_VAL('1)) u_rld_shadow (
        .clk  (clk),
        .rst_n(rst_n),
        .wr   (prot_wr && (addr == AW'(OFF_RLD))),
        .wval (wdata[CNT_W-1:0]),
        .tick (tick),
        .prog (rld_prog),
        .act  (rld_act),
        .busy (rld_busy)
    );

    always_comb begin
        rdata = '0;
        case (addr)
            AW'(OFF_PSC): rdata = DW'(psc_prog);
            AW'(OFF_RLD): rdata = DW'(rld_prog);
            AW'(OFF_STS): rdata = DW'({rld_busy, psc_busy});
            AW'(OFF_WIN): rdata = DW'(win_q);
            AW'(OFF_EWC): begin
                rdata              = DW'(cmp_val);
                rdata[EWC_EN_BIT]  = irq_en;
            end
            default:      rdata = '0;
        endcase
    end

    // R2: closed registers keep their content
    p_closed_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !open_q |=> ($stable(win_q) && $stable(cmp_val) && $stable(irq_en)
                     && $stable(psc_prog) && $stable(rld_prog)));
endmodule

// File: rtl/gt_core.sv
module gt_core
    import gt_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             key_feed,
    input  logic             key_launch,
    input  logic [CNT_W-1:0] rld_act,
    input  logic [CNT_W-1:0] cmp_val,
    input  logic             irq_en,
    input  logic             irq_ack,
    output logic             wdg_rst,
    output logic             early_irq
);
    gt_state_e        state, nxt;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] dec;
    logic             load;
    logic             step;
    logic             hit;
    logic             irq_q;

    assign dec  = cnt - CNT_W'(1);
    assign load = (state != GT_FIRED) && (key_feed || (key_launch && state == GT_IDLE));
    assign step = (state == GT_RUN) && tick && !key_feed && (cnt != '0);
    assign hit  = step && irq_en && (dec == cmp_val);

    always_comb begin
        nxt = state;
        unique case (state)
            GT_IDLE:  if (key_launch) nxt = GT_RUN;
            GT_RUN:   if (tick && !key_feed && cnt == '0) nxt = GT_FIRED;
            GT_FIRED: nxt = GT_FIRED;
            default:  nxt = state;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= GT_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cnt <= '1;
        else if (load) cnt <= rld_act;
        else if (step) cnt <= dec;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       irq_q <= 1'b0;
        else if (hit)     irq_q <= 1'b1;
        else if (irq_ack) irq_q <= 1'b0;
    end

    always_comb begin
        wdg_rst   = (state == GT_FIRED);
        early_irq = irq_q;
    end

    // R6: the fired state is terminal
    p_fired_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == GT_FIRED) |=> (state == GT_FIRED));
    // R6: an unfed tick at zero count fires in the next cycle
    p_fire_on_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == GT_RUN && tick && !key_feed && cnt == '0) |=> wdg_rst);
    // R3: once started, the watchdog never returns to idle
    p_no_stop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state != GT_IDLE) |=> (state != GT_IDLE));
    // R7: a pending early interrupt is held until acknowledged
    p_irq_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_q && !irq_ack) |=> irq_q);
endmodule

// File: rtl/guard_timer.sv
module guard_timer #(
    parameter int CNT_W     = 12,
    parameter int CODE_W    = 4,
    parameter int MIN_LOG   = 2,
    parameter int MAX_LOG   = 10,
    parameter int UPD_TICKS = 2,
    parameter int AW        = 5,
    parameter int DW        = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          wdg_rst,
    output logic          early_irq
);
    logic              tick;
    logic [CODE_W-1:0] psc_act;
    logic [CNT_W-1:0]  rld_act;
    logic [CNT_W-1:0]  cmp_val;
    logic              irq_en;
    logic              key_feed;
    logic              key_launch;
    logic              irq_ack;

    gt_prescaler #(.CODE_W(CODE_W), .MIN_LOG(MIN_LOG), .MAX_LOG(MAX_LOG)) u_psc (
        .clk  (clk),
        .rst_n(rst_n),
        .code (psc_act),
        .tick (tick)
    );

    gt_regs #(.CNT_W(CNT_W), .CODE_W(CODE_W), .UPD_TICKS(UPD_TICKS), .AW(AW), .DW(DW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (bus_wr),
        .addr      (bus_addr),
        .wdata     (bus_wdata),
        .tick      (tick),
        .rdata     (bus_rdata),
        .psc_act   (psc_act),
        .rld_act   (rld_act),
        .cmp_val   (cmp_val),
        .irq_en    (irq_en),
        .key_feed  (key_feed),
        .key_launch(key_launch),
        .irq_ack   (irq_ack)
    );

    gt_core #(.CNT_W(CNT_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .key_feed  (key_feed),
        .key_launch(key_launch),
        .rld_act   (rld_act),
        .cmp_val   (cmp_val),
        .irq_en    (irq_en),
        .irq_ack   (irq_ack),
        .wdg_rst   (wdg_rst),
        .early_irq (early_irq)
    );
endmodule

// File: tb/guard_timer_tb.sv
module guard_timer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        wdg_rst;
    logic        early_irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    guard_timer u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .wdg_rst(wdg_rst), .early_irq(early_irq)
    );

    // behavioural reference model
    int m_pc, m_cprog, m_cact, m_pbusy, m_pn, m_rprog, m_ract, m_rbusy, m_rn;
    int m_win, m_cmp, m_en, m_open, m_state, m_cnt, m_irq;

    task automatic m_reset();
        m_pc = 0; m_cprog = 0; m_cact = 0; m_pbusy = 0; m_pn = 0;
        m_rprog = 4095; m_ract = 4095; m_rbusy = 0; m_rn = 0;
        m_win = 4095; m_cmp = 0; m_en = 0; m_open = 0;
        m_state = 0; m_cnt = 4095; m_irq = 0;
    endtask

    initial m_reset();

    function automatic int m_read(int a);
        case (a)
            4:  return m_cprog;
            8:  return m_rprog;
            12: return m_rbusy * 2 + m_pbusy;
            16: return m_win;
            20: return m_en * 32768 + m_cmp;
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) m_reset();
        else begin
            int eff, per, a, d;
            bit tk, feed, launch, ack, prot;
            eff = (m_cact > 8) ? 8 : m_cact;
            per = 1 << (eff + 2);
            tk = (m_pc == per - 1) || (m_pc >= per);
            m_pc = tk ? 0 : m_pc + 1;
            a = int'(bus_addr); d = int'(bus_wdata);
            feed   = bus_wr && a == 0 && d == 'hAAAA;
            launch = bus_wr && a == 0 && d == 'hCCCC;
            ack    = bus_wr && a == 20 && d[14];
            prot   = bus_wr && m_open != 0;
            // core, using the values held before this edge
            if (m_state == 1) begin
                if (feed) m_cnt = m_ract;
                else if (tk) begin
                    if (m_cnt == 0) m_state = 2;
                    else begin
                        m_cnt = m_cnt - 1;
                        if (m_en != 0 && m_cnt == m_cmp) m_irq = 1;
                        else if (ack) m_irq = 0;
                    end
                end
                if (m_state == 1 && !(tk && !feed && m_cnt != 0 && m_irq == 1) && ack && !(tk && !feed)) m_irq = 0;
                else if (ack && feed) m_irq = 0;
            end else begin
                if (ack) m_irq = 0;
                if (m_state == 0 && (launch || feed)) m_cnt = m_ract;
                if (m_state == 0 && launch) m_state = 1;
            end
            // registers
            if (bus_wr && a == 0) m_open = (d == 'h5555);
            if (prot && a == 16) m_win = d & 'hFFF;
            if (prot && a == 20) begin m_cmp = d & 'hFFF; m_en = (d >> 15) & 1; end
            if (prot && a == 4) begin m_cprog = d & 'hF; m_pbusy = 1; m_pn = 0; end
            else if (m_pbusy != 0 && tk) begin
                if (m_pn == 1) begin m_pbusy = 0; m_cact = m_cprog; end else m_pn++;
            end
            if (prot && a == 8) begin m_rprog = d & 'hFFF; m_rbusy = 1; m_rn = 0; end
            else if (m_rbusy != 0 && tk) begin
                if (m_rn == 1) begin m_rbusy = 0; m_ract = m_rprog; end else m_rn++;
            end
        end
    end

    task automatic chk(bit ok, string tag, int act, int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(wdg_rst == (m_state == 2), "R6 wdg_rst vs model", int'(wdg_rst), int'(m_state == 2));
            chk(early_irq == (m_irq != 0), "R7 early_irq vs model", int'(early_irq), m_irq);
            chk(int'(bus_rdata) == m_read(int'(bus_addr)), "R10 bus_rdata vs model",
                int'(bus_rdata), m_read(int'(bus_addr)));
        end
    end

    task automatic wr(int a, int d);
        @(posedge clk); #2;
        bus_wr = 1'b1; bus_addr = 5'(a); bus_wdata = 16'(d);
        @(posedge clk); #2;
        bus_wr = 1'b0;
    endtask

    task automatic rd(int a, int exp, string tag);
        @(posedge clk); #2;
        bus_addr = 5'(a);
        @(negedge clk);
        chk(int'(bus_rdata) == exp, tag, int'(bus_rdata), exp);
    endtask

    task automatic wait_cyc(int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic level(bit v, bit exp, string tag);
        @(negedge clk);
        chk(v == exp, tag, int'(v), int'(exp));
    endtask

    task automatic do_reset();
        @(posedge clk); #2;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        // R1 reset state
        level(wdg_rst, 1'b0, "R1 wdg_rst after reset");
        level(early_irq, 1'b0, "R1 early_irq after reset");
        rd('h04, 0, "R1 prescaler default");
        rd('h08, 'hFFF, "R1 reload default");
        rd('h10, 'hFFF, "R1 window default");
        rd('h14, 0, "R1 early control default");
        rd('h0C, 0, "R1 status default");
        // R2 closed write is ignored
        wr('h08, 5);
        rd('h08, 'hFFF, "R2 closed reload write ignored");
        // R2 / R9 open and program
        wr('h00, 'h5555);
        wr('h08, 10);
        rd('h0C, 2, "R9 reload busy after write");
        rd('h08, 10, "R9 programmed reload reads back at once");
        wait_cyc(20);
        rd('h0C, 0, "R9 reload busy clears");
        wr('h10, 'h123);
        wr('h14, 'h8004);
        rd('h10, 'h123, "R2 window written while open");
        rd('h14, 'h8004, "R2 early control written while open");
        // R2 relock with another key
        wr('h00, 'h1234);
        wr('h08, 3);
        rd('h08, 10, "R2 relocked reload write ignored");
        // R10 key and unmapped reads
        rd('h00, 0, "R10 key reads zero");
        rd('h18, 0, "R10 unmapped reads zero");
        // R3 start, R7 early interrupt
        wr('h00, 'hCCCC);
        wait_cyc(30);
        level(early_irq, 1'b1, "R7 early_irq raised at compare");
        level(wdg_rst, 1'b0, "R6 no reset before count ends");
        wait_cyc(4);
        level(early_irq, 1'b1, "R7 early_irq held past compare");
        // R8 ack while closed
        wr('h14, 'h4000);
        level(early_irq, 1'b0, "R8 early_irq cleared by ack");
        rd('h14, 'h8004, "R8 closed ack keeps fields");
        // R4 feeding keeps it alive, R3 other keys do not stop it
        for (int i = 0; i < 5; i++) begin
            wr('h00, 'hAAAA);
            wr('h00, 'h0000);
            wait_cyc(14);
        end
        level(wdg_rst, 1'b0, "R4 fed watchdog does not fire");
        level(early_irq, 1'b0, "R4 fed watchdog stays above compare");
        wait_cyc(50);
        level(wdg_rst, 1'b1, "R3 not stoppable, R6 fires after feeding stops");
        level(early_irq, 1'b1, "R7 early_irq before firing");
        wr('h00, 'hAAAA);
        wait_cyc(3);
        level(wdg_rst, 1'b1, "R6 reset output held");
        // R5 code 3 divides by 32
        do_reset();
        wr('h00, 'h5555);
        wr('h04, 3);
        rd('h0C, 1, "R9 prescaler busy after write");
        wr('h08, 2);
        wait_cyc(20);
        rd('h0C, 0, "R9 both updates committed");
        wr('h00, 'hCCCC);
        wait_cyc(58);
        level(wdg_rst, 1'b0, "R5 code 3 not fired early");
        wait_cyc(45);
        level(wdg_rst, 1'b1, "R5 code 3 fired on third tick");
        // R5 saturating code
        do_reset();
        wr('h00, 'h5555);
        wr('h04, 12);
        rd('h04, 12, "R9 saturating code reads back");
        wr('h08, 1);
        wait_cyc(20);
        wr('h00, 'hCCCC);
        wait_cyc(1000);
        level(wdg_rst, 1'b0, "R5 code 12 acts as 1024, not fired");
        wait_cyc(1100);
        level(wdg_rst, 1'b1, "R5 code 12 fired on second tick");
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule